// File: doc/BRIEF.md
# SPI Register Command Target

This block lets an external host reach a 128-byte register file over a four-wire serial link. The host lowers the active-low select, clocks out one opcode byte and then, depending on the opcode, an address, a mask or data bytes. The block decodes the opcode and steps through the phases that opcode needs. Writes and reads walk forward through the addresses for as long as select stays low. A masked update changes only chosen bits of one register. Three status commands return one or two bytes taken from flag inputs that the surrounding logic drives.

The block runs on a system clock at least four times faster than the serial clock. The serial clock, data-in and select pass through a two-stage synchroniser and are then edge-detected. A separate combinational read port lets the surrounding logic see any register directly.

Top module: `spi_reg_slave`

## Requirements
- R1: Raising `csN` ends any command, including one stopped partway through a byte. The first full byte after the next falling `csN` is decoded as an opcode.
- R2: Opcode 0xC0 sets every register to 0x00. Registers also read 0x00 after `rstN`.
- R3: Opcode 0x02 is followed by an address byte (bits 6:0 used) and one or more data bytes. Each data byte is stored at the current address, and the address then advances by one.
- R4: Opcode 0x03 is followed by an address byte. Every later byte shifted out on `miso` is the register at the current address, and the address then advances by one.
- R5: Opcode 0x05 is followed by an address, a mask and a data byte. Register bits whose mask bit is 1 take the data bit. All other bits keep their value.
- R6: Opcode 0xA0 returns `stsByte` and opcode 0xB0 returns `rxsByte`, each as exactly one byte. Any further bytes in the same frame read 0x00.
- R7: Opcode 0xD7 returns two bytes: first {~`devBusy`, `extInfo[14:8]`}, then `extInfo[7:0]`. Bit 7 of the first byte is 1 when the device is ready.
- R8: An opcode outside the set above is ignored until `csN` rises. `miso` stays 0 and no register changes.
- R9: The advancing address wraps from 0x7F to 0x00, for both writes and reads.
- R10: The serial link uses mode 0 with the MSB first. `mosi` is taken on the rising `sck` edge and `miso` only changes after a falling `sck` edge. `miso` is 0 during opcode and address bytes.
- R11: `coreRdData` always shows the register addressed by `coreRdAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x `sck` |
| rstN | input | 1 | Active-low asynchronous-free synchronous reset |
| sck | input | 1 | Serial clock from host, idles low |
| mosi | input | 1 | Serial data from host |
| csN | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data to host |
| stsByte | input | 8 | Value returned by the 0xA0 command |
| rxsByte | input | 8 | Value returned by the 0xB0 command |
| devBusy | input | 1 | Busy flag, inverted into bit 7 of the 0xD7 reply |
| extInfo | input | 15 | Remaining bits of the 0xD7 reply |
| coreRdAddr | input | 7 | Side read port address |
| coreRdData | output | 8 | Side read port data |

## Verification
Assertions check three things on every cycle. A stored write byte, the kept and the taken bits of a masked update, and a command reset must all appear in the register file one cycle after their strobe. Datapath strobes may only fire on a completed byte while the frame is open, and at most one at a time. `miso` must not move except after a falling serial clock edge. Only the bench scenarios can show the rest: opcode decoding across whole frames, address advance and wrap over bursts, reply contents of the status commands, silence of unknown opcodes, and recovery after a frame cut mid-byte.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam logic [7:0] OP_RESET   = 8'hC0;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_BITMOD  = 8'h05;
  localparam logic [7:0] OP_STATUS  = 8'hA0;
  localparam logic [7:0] OP_RXSTAT  = 8'hB0;
  localparam logic [7:0] OP_EXTSTAT = 8'hD7;

  typedef enum logic [2:0] {
    TX_ZERO, TX_REG, TX_STS, TX_RXS, TX_EXTHI, TX_EXTLO
  } txSel_e;

  typedef struct packed {
    logic   ldAddr;
    logic   wrData;
    logic   ldMask;
    logic   bmData;
    logic   swReset;
    txSel_e txSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic mosiIn,
  input  logic csNIn,
  output logic sckRise,
  output logic sckFall,
  output logic mosiBit,
  output logic csActive
);
  logic [STAGES-1:0] sckPipe, mosiPipe, csPipe;
  logic sckPrev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sckPipe[g]  <= 1'b0;
          mosiPipe[g] <= 1'b0;
          csPipe[g]   <= 1'b1;
        end else if (g == 0) begin
          sckPipe[g]  <= sckIn;
          mosiPipe[g] <= mosiIn;
          csPipe[g]   <= csNIn;
        end else begin
          sckPipe[g]  <= sckPipe[g-1];
          mosiPipe[g] <= mosiPipe[g-1];
          csPipe[g]   <= csPipe[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckPipe[STAGES-1];
  end

  assign csActive = ~csPipe[STAGES-1];
  assign mosiBit  = mosiPipe[STAGES-1];
  assign sckRise  = csActive &  sckPipe[STAGES-1] & ~sckPrev;
  assign sckFall  = csActive & ~sckPipe[STAGES-1] &  sckPrev;
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csActive,
  input  logic         byteDone,
  input  logic [7:0]   rxByte,
  output ctrlStrobes_t ctl
);
  typedef enum logic [3:0] {
    PH_OPCODE, PH_WADDR, PH_RADDR, PH_BADDR, PH_WDATA, PH_RDATA,
    PH_BMASK, PH_BDATA, PH_STS, PH_RXS, PH_EXTHI, PH_EXTLO, PH_IGNORE
  } phase_e;

  phase_e phase, phaseNext;

  always_comb begin
    phaseNext   = phase;
    ctl         = '0;
    ctl.txSel   = TX_ZERO;
    unique case (phase)
      PH_RDATA:  ctl.txSel = TX_REG;
      PH_STS:    ctl.txSel = TX_STS;
      PH_RXS:    ctl.txSel = TX_RXS;
      PH_EXTHI:  ctl.txSel = TX_EXTHI;
      PH_EXTLO:  ctl.txSel = TX_EXTLO;
      default:   ctl.txSel = TX_ZERO;
    endcase
    if (byteDone) begin
      unique case (phase)
        PH_OPCODE: begin
          unique case (rxByte)
            OP_RESET:   begin ctl.swReset = 1'b1; phaseNext = PH_IGNORE; end
            OP_WRITE:   phaseNext = PH_WADDR;
            OP_READ:    phaseNext = PH_RADDR;
            OP_BITMOD:  phaseNext = PH_BADDR;
            OP_STATUS:  phaseNext = PH_STS;
            OP_RXSTAT:  phaseNext = PH_RXS;
            OP_EXTSTAT: phaseNext = PH_EXTHI;
            default:    phaseNext = PH_IGNORE;
          endcase
        end
        PH_WADDR:  begin ctl.ldAddr = 1'b1; phaseNext = PH_WDATA; end
        PH_RADDR:  begin ctl.ldAddr = 1'b1; phaseNext = PH_RDATA; end
        PH_BADDR:  begin ctl.ldAddr = 1'b1; phaseNext = PH_BMASK; end
        PH_BMASK:  begin ctl.ldMask = 1'b1; phaseNext = PH_BDATA; end
        PH_BDATA:  begin ctl.bmData = 1'b1; phaseNext = PH_IGNORE; end
        PH_WDATA:  ctl.wrData = 1'b1;
        PH_RDATA:  phaseNext = PH_RDATA;
        PH_STS, PH_RXS, PH_EXTLO: phaseNext = PH_IGNORE;
        PH_EXTHI:  phaseNext = PH_EXTLO;
        default:   phaseNext = PH_IGNORE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !csActive) phase <= PH_OPCODE;
    else                    phase <= phaseNext;
  end

  p_frame_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> phase == PH_OPCODE);
  p_strobe_on_byte_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ldAddr || ctl.wrData || ctl.ldMask || ctl.bmData || ctl.swReset)
      |-> (byteDone && csActive));
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.ldAddr, ctl.wrData, ctl.ldMask, ctl.bmData, ctl.swReset}));
  p_reset_from_opcode_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.swReset |-> (phase == PH_OPCODE && rxByte == OP_RESET));
endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EXT_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic              mosiBit,
  input  logic              csActive,
  input  ctrlStrobes_t      ctl,
  input  logic [7:0]        stsByte,
  input  logic [7:0]        rxsByte,
  input  logic              devBusy,
  input  logic [EXT_W-1:0]  extInfo,
  input  logic [ADDR_W-1:0] coreRdAddr,
  output logic              byteDone,
  output logic [7:0]        rxByte,
  output logic              miso,
  output logic [7:0]        coreRdData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

  logic [2:0]        bitCnt;
  logic [7:0]        rxShift, txShift, txNext, maskReg, wrVal;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        mem [DEPTH];
  logic              txLoad;

  assign rxByte   = {rxShift[6:0], mosiBit};
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign txLoad   = sckFall && (bitCnt == 3'd0);

  always_ff @(posedge clk) begin
    if (!rstN || !csActive) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (sckRise) begin
      bitCnt  <= bitCnt + 3'd1;
      rxShift <= rxByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr    <= '0;
      maskReg <= '0;
    end else begin
      if (ctl.ldAddr)
        addr <= rxByte[ADDR_W-1:0];
      else if (ctl.wrData || (txLoad && ctl.txSel == TX_REG))
        addr <= addr + ADDR_ONE;
      if (ctl.ldMask)
        maskReg <= rxByte;
    end
  end

  assign wrVal = ctl.wrData ? rxByte
                            : ((mem[addr] & ~maskReg) | (rxByte & maskReg));

  always_ff @(posedge clk) begin
    if (!rstN || ctl.swReset) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (ctl.wrData || ctl.bmData) begin
      mem[addr] <= wrVal;
    end
  end

  assign coreRdData = mem[coreRdAddr];

  always_comb begin
    unique case (ctl.txSel)
      TX_REG:   txNext = mem[addr];
      TX_STS:   txNext = stsByte;
      TX_RXS:   txNext = rxsByte;
      TX_EXTHI: txNext = {~devBusy, extInfo[EXT_W-1:8]};
      TX_EXTLO: txNext = extInfo[7:0];
      default:  txNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !csActive)  txShift <= '0;
    else if (txLoad)         txShift <= txNext;
    else if (sckFall)        txShift <= {txShift[6:0], 1'b0};
  end

  assign miso = txShift[7];

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrData |=> mem[$past(addr)] == $past(rxByte));
  p_bm_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.bmData |=> ((mem[$past(addr)] ^ $past(mem[addr])) & ~$past(maskReg)) == 8'h00);
  p_bm_take_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.bmData |=> ((mem[$past(addr)] ^ $past(rxByte)) & $past(maskReg)) == 8'h00);
  p_cmd_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.swReset |=> (mem[0] == 8'h00 && mem[ADDR_TOP] == 8'h00));
  p_miso_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && !sckFall) |=> $stable(miso));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int EXT_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              mosi,
  input  logic              csN,
  output logic              miso,
  input  logic [7:0]        stsByte,
  input  logic [7:0]        rxsByte,
  input  logic              devBusy,
  input  logic [EXT_W-1:0]  extInfo,
  input  logic [ADDR_W-1:0] coreRdAddr,
  output logic [7:0]        coreRdData
);
  logic sckRise, sckFall, mosiBit, csActive, byteDone;
  logic [7:0] rxByte;
  ctrlStrobes_t ctl;

  spi_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sckIn(sck), .mosiIn(mosi), .csNIn(csN),
    .sckRise(sckRise), .sckFall(sckFall), .mosiBit(mosiBit), .csActive(csActive)
  );

  spi_reg_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .byteDone(byteDone),
    .rxByte(rxByte), .ctl(ctl)
  );

  spi_reg_dp #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) i_dp (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .mosiBit(mosiBit), .csActive(csActive), .ctl(ctl),
    .stsByte(stsByte), .rxsByte(rxsByte), .devBusy(devBusy), .extInfo(extInfo),
    .coreRdAddr(coreRdAddr), .byteDone(byteDone), .rxByte(rxByte),
    .miso(miso), .coreRdData(coreRdData)
  );
endmodule

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, csN = 1'b1;
  logic miso;
  logic [7:0] stsByte = 8'h00, rxsByte = 8'h00;
  logic devBusy = 1'b0;
  logic [14:0] extInfo = '0;
  logic [6:0] coreRdAddr = '0;
  logic [7:0] coreRdData;

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_reg_slave i_spi_reg_slave (
    .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .csN(csN), .miso(miso),
    .stsByte(stsByte), .rxsByte(rxsByte), .devBusy(devBusy), .extInfo(extInfo),
    .coreRdAddr(coreRdAddr), .coreRdData(coreRdData)
  );

  // {address, data} pairs: write then read back
  localparam logic [14:0] TBL [0:7] = '{
    {7'h00, 8'h3C}, {7'h01, 8'hFF}, {7'h10, 8'hF0}, {7'h2A, 8'h55},
    {7'h40, 8'hAA}, {7'h5E, 8'h01}, {7'h7F, 8'h80}, {7'h33, 8'h96}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      rx[i] = miso;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic csLow();
    @(negedge clk); csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (4) @(negedge clk); csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic spiWrite(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    csLow(); xfer(8'h02, 8, r); xfer({1'b0, a}, 8, r); xfer(d, 8, r); csHigh();
  endtask

  task automatic spiRead(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] r;
    csLow(); xfer(8'h03, 8, r); xfer({1'b0, a}, 8, r); xfer(8'h00, 8, d); csHigh();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++; errors++;
      $display("FAIL watchdog actual %h expected %h", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, r2, r3;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    coreRdAddr = 7'h05; #1;
    check("R2 reset value", coreRdData, 8'h00);
    check("R10 miso idle", {7'b0, miso}, 8'h00);

    // table walk: write, read back over SPI and the side port
    for (int k = 0; k < 8; k++) begin
      spiWrite(TBL[k][14:8], TBL[k][7:0]);
      spiRead(TBL[k][14:8], r);
      check("R4 read back", r, TBL[k][7:0]);
      coreRdAddr = TBL[k][14:8]; #1;
      check("R11 side port", coreRdData, TBL[k][7:0]);
    end

    // opcode and address bytes return zero
    csLow(); xfer(8'h03, 8, r); xfer(8'h10, 8, r2); xfer(8'h00, 8, r3); csHigh();
    check("R10 opcode byte zero", r, 8'h00);
    check("R10 address byte zero", r2, 8'h00);
    check("R10 data msb first", r3, 8'hF0);

    // burst write wrapping past the top
    csLow(); xfer(8'h02, 8, r); xfer(8'h7E, 8, r);
    xfer(8'hA1, 8, r); xfer(8'hB2, 8, r); xfer(8'hC3, 8, r); csHigh();
    coreRdAddr = 7'h7F; #1; check("R3 burst second", coreRdData, 8'hB2);
    coreRdAddr = 7'h00; #1; check("R9 write wrap", coreRdData, 8'hC3);
    csLow(); xfer(8'h03, 8, r); xfer(8'h7E, 8, r);
    xfer(8'h00, 8, r); xfer(8'h00, 8, r2); xfer(8'h00, 8, r3); csHigh();
    check("R4 burst first", r, 8'hA1);
    check("R4 burst second", r2, 8'hB2);
    check("R9 read wrap", r3, 8'hC3);

    // masked update: 0xF0 with mask 0x3C data 0xA5 -> 0xE4
    csLow(); xfer(8'h05, 8, r); xfer(8'h10, 8, r); xfer(8'h3C, 8, r); xfer(8'hA5, 8, r); csHigh();
    coreRdAddr = 7'h10; #1; check("R5 masked update", coreRdData, 8'hE4);

    // short status commands
    stsByte = 8'h5A; rxsByte = 8'h81;
    csLow(); xfer(8'hA0, 8, r); xfer(8'h00, 8, r2); xfer(8'h00, 8, r3); csHigh();
    check("R6 status byte", r2, 8'h5A);
    check("R6 status only once", r3, 8'h00);
    csLow(); xfer(8'hB0, 8, r); xfer(8'h00, 8, r2); xfer(8'h00, 8, r3); csHigh();
    check("R6 rx status byte", r2, 8'h81);
    check("R6 rx status only once", r3, 8'h00);

    // extended status
    extInfo = 15'h1234; devBusy = 1'b0;
    csLow(); xfer(8'hD7, 8, r); xfer(8'h00, 8, r2); xfer(8'h00, 8, r3); csHigh();
    check("R7 ext high ready", r2, 8'h92);
    check("R7 ext low", r3, 8'h34);
    devBusy = 1'b1;
    csLow(); xfer(8'hD7, 8, r); xfer(8'h00, 8, r2); csHigh();
    check("R7 ext high busy", r2, 8'h12);

    // unknown opcode
    csLow(); xfer(8'h55, 8, r); xfer(8'h10, 8, r2); xfer(8'hFF, 8, r3); csHigh();
    check("R8 no reply addr", r2, 8'h00);
    check("R8 no reply data", r3, 8'h00);
    spiRead(7'h10, r);
    check("R8 register untouched", r, 8'hE4);

    // frame cut mid-byte, then mid-command
    csLow(); xfer(8'h02, 3, r); csHigh();
    spiRead(7'h10, r);
    check("R1 after partial byte", r, 8'hE4);
    csLow(); xfer(8'h02, 8, r); xfer(8'h20, 8, r); xfer(8'h11, 8, r); csHigh();
    spiRead(7'h20, r);
    check("R1 new opcode after cut", r, 8'h11);

    // reset command
    csLow(); xfer(8'hC0, 8, r); csHigh();
    coreRdAddr = 7'h10; #1; check("R2 command clears", coreRdData, 8'h00);
    spiRead(7'h7F, r);
    check("R2 command clears top", r, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule